// File: doc/BRIEF.md
# Dual-Die Asynchronous Byte Memory Controller

This block sits between a synchronous host and an external asynchronous byte-wide static memory made of two half-size dies. The dies share their address lines and an 8-bit bidirectional data bus. Each die has its own active-low select and its own active-low write strobe. A single active-low output enable is common to both dies. The host presents one request at a time with a valid flag, a write flag, a 20-bit byte address and write data. The controller answers reads with a one-clock data-valid pulse.

The top host address bit picks the die, and the lower 19 bits go unchanged to the shared address lines. Every access is a fixed sequence of clock-counted phases. A read holds the select and output enable for a parameterised access time, then captures the bus and goes through one recovery cycle. A write keeps output enable high, lowers select and strobe, and holds the bus undriven for a turnaround interval. It then drives the data for the write pulse, and finally raises select and strobe while the data is still held for one more cycle. Whenever no access is in progress, both dies are deselected so the memory stays in standby.

Top module: `dual_die_sram_ctrl`

## Requirements
- R1: Out of reset and whenever `host_ready` is high, both die selects and both write strobes are high, `mem_oe_n` is high and `bus_drive` is low.
- R2: Host address bit 19 set selects die 1 (`mem_sel_n[1]` low) and clear selects die 0 (`mem_sel_n[0]` low); host bits 18:0 appear on `mem_addr`.
- R3: At no time are both die selects low together.
- R4: A read holds the chosen select and `mem_oe_n` low, with that die's strobe high, for RD_CYC cycles. The bus is captured at the end of the last of them, and `rd_valid` is high for exactly one cycle with the captured byte on `rd_data`.
- R5: A write keeps `mem_oe_n` high and lowers the chosen select and strobe together. `bus_drive` stays low for the first TURN_CYC cycles of the strobe, then is high for WR_CYC cycles while the strobe is low.
- R6: A write ends with select and strobe rising on the same edge while `bus_drive` is still high with the same data; `bus_drive` drops one cycle later.
- R7: `host_ready` falls on the cycle after a request is accepted and stays low until the access sequence is complete.
- R8: `mem_addr` and `bus_out` do not change while any die select is low.
- R9: The controller never raises `bus_drive` while `mem_oe_n` is low.
- R10: A read occupies RD_CYC+1 cycles before `host_ready` returns (access plus one recovery cycle); a write occupies TURN_CYC+WR_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Request present |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Byte address; bit 19 picks the die |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller idle, request accepted when valid |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 19 | Shared die address lines |
| mem_sel_n | output | 2 | Active-low select, one per die |
| mem_we_n | output | 2 | Active-low write strobe, one per die |
| mem_oe_n | output | 1 | Shared active-low output enable |
| bus_out | output | 8 | Data the controller places on the bus |
| bus_drive | output | 1 | Controller drives the bus when high |
| bus_in | input | 8 | Data seen on the bus |

## Verification
A wrong sequencer state or count shows up at the memory pins within the same access. Too short a read makes the memory model hand back a placeholder byte instead of stored data, and the scoreboard reports it on the next `rd_valid`. A bad bank latch or decode lowers the wrong select, and this is caught at the first cycle after acceptance and again when the byte read back differs. Errors in write timing or turnaround, such as driving during the strobe's first cycle, releasing data before the strobe rises, or too few driven cycles, are flagged at the cycle where the memory model commits the byte. A wrong ready or recovery length shows as a wrong count of cycles from acceptance to ready.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    localparam int HOST_AW = 20;
    localparam int DIE_AW  = HOST_AW - 1;
    localparam int DATA_W  = 8;
    localparam int N_DIES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RCV,
        ST_TURN,
        ST_WR,
        ST_HOLD
    } seq_state_t;

    typedef struct packed {
        logic              bank;
        logic [DIE_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } acc_req_t;

    function automatic logic [N_DIES-1:0] die_onehot(input logic bank);
        logic [N_DIES-1:0] v;
        v = '0;
        v[bank] = 1'b1;
        return v;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sramc_bank_decode.sv
module sramc_bank_decode
    import sramc_pkg::*;
(
    input  logic [HOST_AW-1:0] host_addr,
    output logic               bank,
    output logic [DIE_AW-1:0]  die_addr
);
    always_comb begin
        bank     = host_addr[HOST_AW-1];
        die_addr = host_addr[DIE_AW-1:0];
    end
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int RD_CYC   = 3,
    parameter int WR_CYC   = 3,
    parameter int TURN_CYC = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       is_write,
    output seq_state_t state,
    output logic       rd_capture
);
    localparam int CNT_MAX = max3(RD_CYC, WR_CYC, TURN_CYC);
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TN_LAST = CNT_W'(TURN_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign rd_capture = (state == ST_RD) && (cnt == RD_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) state <= is_write ? ST_TURN : ST_RD;
                end
                ST_RD: begin
                    if (cnt == RD_LAST) begin
                        state <= ST_RCV;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RCV: state <= ST_IDLE;
                ST_TURN: begin
                    if (cnt == TN_LAST) begin
                        state <= ST_WR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WR: begin
                    if (cnt == WR_LAST) begin
                        state <= ST_HOLD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: state <= ST_IDLE;
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R4
    capture_once_chk: assert property (@(posedge clk) disable iff (rst)
        rd_capture |=> (state == ST_RCV));

    // R6
    hold_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> ($past(state) == ST_WR));
endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
    import sramc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  acc_req_t          req_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output acc_req_t          req_q,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (start) req_q <= req_in;
            rd_valid <= capture;
            if (capture) rd_data <= bus_in;
        end
    end

    // R4
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/dual_die_sram_ctrl.sv
module dual_die_sram_ctrl
    import sramc_pkg::*;
#(
    parameter int RD_CYC   = 3,
    parameter int WR_CYC   = 3,
    parameter int TURN_CYC = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic               host_ready,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic [DIE_AW-1:0]  mem_addr,
    output logic [N_DIES-1:0]  mem_sel_n,
    output logic [N_DIES-1:0]  mem_we_n,
    output logic               mem_oe_n,
    output logic [DATA_W-1:0]  bus_out,
    output logic               bus_drive,
    input  logic [DATA_W-1:0]  bus_in
);
    seq_state_t        state;
    logic              start;
    logic              capture;
    logic              dec_bank;
    logic [DIE_AW-1:0] dec_addr;
    acc_req_t          req_in;
    acc_req_t          req_q;
    logic [N_DIES-1:0] die_mask;

    sramc_bank_decode u_dec (
        .host_addr (host_addr),
        .bank      (dec_bank),
        .die_addr  (dec_addr)
    );

    assign start  = host_valid && host_ready;
    assign req_in = '{bank: dec_bank, addr: dec_addr, data: host_wdata};

    sramc_seq #(
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .is_write   (host_write),
        .state      (state),
        .rd_capture (capture)
    );

    sramc_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req_in   (req_in),
        .capture  (capture),
        .bus_in   (bus_in),
        .req_q    (req_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign die_mask = die_onehot(req_q.bank);

    always_comb begin
        host_ready = (state == ST_IDLE);
        mem_addr   = req_q.addr;
        bus_out    = req_q.data;
        mem_oe_n   = (state != ST_RD);
        bus_drive  = (state == ST_WR) || (state == ST_HOLD);
        mem_sel_n  = '1;
        mem_we_n   = '1;
        if (state == ST_RD || state == ST_TURN || state == ST_WR)
            mem_sel_n = ~die_mask;
        if (state == ST_TURN || state == ST_WR)
            mem_we_n = ~die_mask;
    end

    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (&mem_sel_n && &mem_we_n && mem_oe_n && !bus_drive));

    // R3
    one_die_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~mem_sel_n) <= 1);

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_ready) |=> !host_ready);

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_sel_n) && !(&$past(mem_sel_n))) |-> ($stable(mem_addr) && $stable(bus_out)));

    // R9
    no_fight_chk: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> mem_oe_n);

    // R6
    data_held_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_we_n[0]) || $rose(mem_we_n[1])) |-> (bus_drive && $stable(bus_out)));
endmodule

// File: tb/dual_die_sram_ctrl_tb.sv
module dual_die_sram_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RD_CYC   = 3;
    localparam int WR_CYC   = 3;
    localparam int TURN_CYC = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [19:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic [1:0]  mem_sel_n;
    logic [1:0]  mem_we_n;
    logic        mem_oe_n;
    logic [7:0]  bus_out;
    logic        bus_drive;
    logic [7:0]  bus_in = 8'h00;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_die_sram_ctrl #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)) u_dut (
        .clk(clk), .rst(rst), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .bus_out(bus_out), .bus_drive(bus_drive), .bus_in(bus_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural memory model and shadow reference
    logic [7:0] die0 [int];
    logic [7:0] die1 [int];
    logic [7:0] shadow [int];
    logic [7:0] expq [$];

    function automatic logic [7:0] mread(input int b, input int a);
        if (b == 0) return die0.exists(a) ? die0[a] : 8'h00;
        return die1.exists(a) ? die1[a] : 8'h00;
    endfunction

    bit pact [2] = '{0, 0};
    int dcnt [2] = '{0, 0};
    int rcnt [2] = '{0, 0};
    int dual_sel_err = 0;
    int fight_err = 0;
    bit prev_rdv = 0;

    always @(negedge clk) begin
        if (!rst) begin
            logic [7:0] drv;
            bit any_rd;
            drv = 8'h00;
            any_rd = 0;
            if (mem_sel_n == 2'b00) dual_sel_err++;
            for (int b = 0; b < 2; b++) begin
                bit act;
                bit rc;
                act = !mem_sel_n[b] && !mem_we_n[b];
                rc  = !mem_sel_n[b] && !mem_oe_n && mem_we_n[b];
                if (act && !pact[b]) begin
                    // R5 turnaround: no drive on first strobe cycle
                    chk(!bus_drive, "R5 turnaround", bus_drive, 0);
                    dcnt[b] = 0;
                end
                if (act && bus_drive) dcnt[b]++;
                if (!act && pact[b]) begin
                    // R6 data held at release, R5 pulse length
                    chk(bus_drive, "R6 hold at release", bus_drive, 1);
                    chk(dcnt[b] >= WR_CYC, "R5 driven cycles", dcnt[b], WR_CYC);
                    if (b == 0) die0[int'(mem_addr)] = bus_out;
                    else        die1[int'(mem_addr)] = bus_out;
                end
                pact[b] = act;
                rcnt[b] = rc ? rcnt[b] + 1 : 0;
                if (rc) begin
                    any_rd = 1;
                    drv = (rcnt[b] >= RD_CYC) ? mread(b, int'(mem_addr)) : 8'hA5;
                end
            end
            if (any_rd && bus_drive) fight_err++;
            bus_in = drv;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                // R4 single pulse
                chk(!prev_rdv, "R4 single pulse", prev_rdv, 0);
                if (expq.size() == 0) begin
                    chk(0, "R4 unexpected rd_valid", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    chk(rd_data == e, "R4 read data", rd_data, e);
                end
            end
            prev_rdv = rd_valid;
        end
    end

    task automatic do_op(input bit wr, input logic [19:0] a, input logic [7:0] d);
        int n;
        logic [1:0] exp_sel;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1; host_write = wr; host_addr = a; host_wdata = d;
        if (wr) shadow[int'(a)] = d;
        else expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
        @(negedge clk);
        host_valid = 0;
        // R7
        chk(!host_ready, "R7 ready low", host_ready, 0);
        exp_sel = a[19] ? 2'b01 : 2'b10;
        // R2
        chk(mem_sel_n == exp_sel, "R2 die select", mem_sel_n, exp_sel);
        chk(mem_addr == a[18:0], "R2 die address", mem_addr, a[18:0]);
        if (wr) chk(mem_oe_n && mem_we_n == exp_sel, "R5 write strobes", {mem_oe_n, mem_we_n}, {1'b1, exp_sel});
        else    chk(!mem_oe_n && mem_we_n == 2'b11, "R4 read enables", {mem_oe_n, mem_we_n}, 3'b011);
        n = 1;
        while (!host_ready && n < 50) begin @(negedge clk); n++; end
        // R10
        chk(n == (wr ? TURN_CYC + WR_CYC + 2 : RD_CYC + 2), "R10 cycle length", n,
            wr ? TURN_CYC + WR_CYC + 2 : RD_CYC + 2);
    endtask

    task automatic chk_idle(input string tag);
        chk(host_ready && mem_sel_n == 2'b11 && mem_we_n == 2'b11 && mem_oe_n && !bus_drive && !rd_valid,
            tag, {host_ready, mem_sel_n, mem_we_n, mem_oe_n, bus_drive, rd_valid}, 9'b1_11_11_1_0_0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        chk_idle("R1 reset state");

        do_op(1, 20'h00010, 8'h3C);
        do_op(1, 20'h80010, 8'hC3);
        do_op(0, 20'h00010, 8'h00);
        do_op(0, 20'h80010, 8'h00);
        for (int i = 0; i < 6; i++) begin
            logic [19:0] a;
            a = {i[0], 19'(i * 19'h1357 + 19'h7FF00)};
            do_op(1, a, 8'(8'h11 * (i + 1)));
        end
        for (int i = 5; i >= 0; i--) begin
            logic [19:0] a;
            a = {i[0], 19'(i * 19'h1357 + 19'h7FF00)};
            do_op(0, a, 8'h00);
        end
        do_op(0, 20'h44444, 8'h00);
        do_op(1, 20'hFFFFF, 8'hA5);
        do_op(1, 20'hFFFFF, 8'h5A);
        do_op(0, 20'hFFFFF, 8'h00);
        do_op(0, 20'h7FFFF, 8'h00);
        repeat (3) @(negedge clk);
        chk_idle("R1 standby after traffic");
        // R3
        chk(dual_sel_err == 0, "R3 single die", dual_sel_err, 0);
        // R9
        chk(fight_err == 0, "R9 no bus fight", fight_err, 0);
        // R8 checked by mem_addr matching at release; queue drained
        chk(expq.size() == 0, "R4 R8 all reads returned", expq.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule